// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block is a single-cycle multiplier with an accumulator. It holds two 16-bit operand registers, A and B, and a 40-bit two's-complement accumulator, which leaves 8 guard bits above a 32-bit result. Software drives it through a four-entry write port. A mode word sets the operand interpretation, the accumulate behaviour, rounding and auto-increment. Writing the B operand starts an operation, and the new accumulator value is visible at the same clock edge. A command word performs one action on the stored state: clearing, negation, shifts, or a byte-granular right alignment.

The map is address 0 for the mode word, 1 for operand A, 2 for operand B (this write starts an operation) and 3 for the command word. In the command word, bits [2:0] hold the opcode: 0 no action, 1 clear, 2 negate accumulator, 3 negate A, 4 negate B, 5 shift left, 6 shift right, 7 align. Bits [7:3] hold the shift amount. For alignment, bits [4:3] give the byte count and bit 5 selects sign fill.

Auto-increment lets a feeding engine stream array elements into B while A walks an index, or the reverse.

Top module: `mac_engine`

## Requirements
- R1: A write to address 2 loads B and completes an operation in that same clock edge: the accumulator holds the result one cycle after the write is presented.
- R2: Mode bit 0 clear makes the accumulator take the product alone. Mode bit 0 set adds the product to the accumulator.
- R3: Mode bit 1 set treats A and B as signed 16-bit values. Mode bit 1 clear treats them as unsigned. The accumulator is always two's complement.
- R4: Mode bit 2 set selects fractional mode, in which the product is doubled (Q15 x Q15 gives Q31).
- R5: Mode bit 3 set adds 2^15 to the result and clears bits [15:0]. It then clamps to 0x7FFFFFFF or -2^31 (sign-extended) when the result lies outside the signed 32-bit range, and sets the sticky saturation flag.
- R6: Mode bit 4 increments A and mode bit 5 increments B after each operation. The product uses the values before the increment.
- R7: Opcode 5 shifts the accumulator left and opcode 6 shifts it right arithmetically, by the amount in bits [7:3]. An amount of 0 means one bit.
- R8: Opcodes 2, 3 and 4 replace the accumulator, A or B respectively with its two's-complement negation.
- R9: Opcode 7 shifts the accumulator right by 8 x bits[4:3] bit positions. Vacated bits take the sign when bit 5 is set and zeros otherwise.
- R10: Opcode 1 zeroes the accumulator and both sticky flags. The zero flag is high exactly when the accumulator is zero, including after reset.
- R11: An operation whose exact result lies outside the signed 40-bit range sets a sticky overflow flag. The flag stays set until a clear command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 16 | Write data |
| accOut | output | 40 | Accumulator |
| aOut | output | 16 | Operand A register |
| bOut | output | 16 | Operand B register |
| zeroFlag | output | 1 | Accumulator equals zero |
| ovfFlag | output | 1 | Sticky 40-bit overflow |
| satFlag | output | 1 | Sticky saturation |

## Verification
Two functions meet in one cycle: the multiply and the operand auto-increment. The B write that starts a product is also the edge at which A or B advances. The bench enables increment and issues back-to-back B writes. It expects each product to use the operand value from before that edge, and it expects the operand port to show the incremented value afterwards. Rounding and saturation also land in the same cycle. Their combination is judged by driving accumulations just past each end of the 32-bit range and comparing against the exact clamp values.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CLR   = 3'd1,
    OP_NEGAC = 3'd2,
    OP_NEGA  = 3'd3,
    OP_NEGB  = 3'd4,
    OP_SHL   = 3'd5,
    OP_SHR   = 3'd6,
    OP_ALIGN = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    ADR_MODE = 2'd0,
    ADR_A    = 2'd1,
    ADR_B    = 2'd2,
    ADR_CMD  = 2'd3
  } addr_e;

  typedef struct packed {
    logic       accMode;
    logic       signedOps;
    logic       fracMode;
    logic       roundSat;
    logic       incA;
    logic       incB;
    logic       loadA;
    logic       doMac;
    logic       clrAcc;
    logic       negAcc;
    logic       negA;
    logic       negB;
    logic       shl;
    logic       shr;
    logic [4:0] shAmt;
    logic       align;
    logic [1:0] alignBytes;
    logic       alignSigned;
  } ctl_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl #(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrAddr,
  input  logic [OP_W-1:0] wrData,
  output mac_pkg::ctl_t   ctl
);
  import mac_pkg::*;

  localparam int MODE_W = 6;

  logic [MODE_W-1:0] modeReg;
  cmd_e              opCode;
  logic [4:0]        amtField;

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= '0;
    else if (wrEn && addr_e'(wrAddr) == ADR_MODE) modeReg <= wrData[MODE_W-1:0];
  end

  assign opCode   = cmd_e'(wrData[2:0]);
  assign amtField = wrData[7:3];

  always_comb begin
    ctl             = '0;
    ctl.accMode     = modeReg[0];
    ctl.signedOps   = modeReg[1];
    ctl.fracMode    = modeReg[2];
    ctl.roundSat    = modeReg[3];
    ctl.incA        = modeReg[4];
    ctl.incB        = modeReg[5];
    ctl.shAmt       = (amtField == 5'd0) ? 5'd1 : amtField;
    ctl.alignBytes  = wrData[4:3];
    ctl.alignSigned = wrData[5];
    if (wrEn) begin
      unique case (addr_e'(wrAddr))
        ADR_A:   ctl.loadA = 1'b1;
        ADR_B:   ctl.doMac = 1'b1;
        ADR_CMD: begin
          unique case (opCode)
            OP_CLR:   ctl.clrAcc = 1'b1;
            OP_NEGAC: ctl.negAcc = 1'b1;
            OP_NEGA:  ctl.negA   = 1'b1;
            OP_NEGB:  ctl.negB   = 1'b1;
            OP_SHL:   ctl.shl    = 1'b1;
            OP_SHR:   ctl.shr    = 1'b1;
            OP_ALIGN: ctl.align  = 1'b1;
            default:  ;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mac_dpath.sv
module mac_dpath #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mac_pkg::ctl_t    ctl,
  input  logic [OP_W-1:0]  wrData,
  output logic [ACC_W-1:0] accOut,
  output logic [OP_W-1:0]  aOut,
  output logic [OP_W-1:0]  bOut,
  output logic             zeroFlag,
  output logic             ovfFlag,
  output logic             satFlag
);
  localparam int WIDE    = ACC_W + 2;
  localparam int RND_POS = OP_W - 1;
  localparam logic signed [WIDE-1:0] RND_ADD  = WIDE'(1) <<< RND_POS;
  localparam logic signed [WIDE-1:0] LOW_MASK = (WIDE'(1) <<< (RND_POS + 1)) - 1;
  localparam logic signed [WIDE-1:0] SAT_MAX  = (WIDE'(1) <<< (SAT_W - 1)) - 1;
  localparam logic signed [WIDE-1:0] SAT_MIN  = -SAT_MAX - 1;

  logic [ACC_W-1:0]       accReg;
  logic [OP_W-1:0]        aReg, bReg;
  logic signed [WIDE-1:0] aExt, bExt, prodW, accExt, sumW, rndW, macRes;
  logic                   ovf40, satHi, satLo;

  always_comb begin
    aExt   = $signed({{(WIDE-OP_W){ctl.signedOps & aReg[OP_W-1]}}, aReg});
    bExt   = $signed({{(WIDE-OP_W){ctl.signedOps & wrData[OP_W-1]}}, wrData});
    prodW  = aExt * bExt;
    if (ctl.fracMode) prodW = prodW <<< 1;
    accExt = $signed({{(WIDE-ACC_W){accReg[ACC_W-1]}}, accReg});
    sumW   = ctl.accMode ? accExt + prodW : prodW;
    ovf40  = !((&sumW[WIDE-1:ACC_W-1]) || !(|sumW[WIDE-1:ACC_W-1]));
    rndW   = (sumW + RND_ADD) & ~LOW_MASK;
    satHi  = ctl.roundSat && (rndW > SAT_MAX);
    satLo  = ctl.roundSat && (rndW < SAT_MIN);
    if (satHi)             macRes = SAT_MAX;
    else if (satLo)        macRes = SAT_MIN;
    else if (ctl.roundSat) macRes = rndW;
    else                   macRes = sumW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg  <= '0;
      aReg    <= '0;
      bReg    <= '0;
      ovfFlag <= 1'b0;
      satFlag <= 1'b0;
    end else begin
      if (ctl.loadA) aReg <= wrData;
      if (ctl.doMac) begin
        accReg <= macRes[ACC_W-1:0];
        bReg   <= ctl.incB ? wrData + 1'b1 : wrData;
        if (ctl.incA)   aReg    <= aReg + 1'b1;
        if (ovf40)      ovfFlag <= 1'b1;
        if (satHi || satLo) satFlag <= 1'b1;
      end
      if (ctl.clrAcc) begin
        accReg  <= '0;
        ovfFlag <= 1'b0;
        satFlag <= 1'b0;
      end
      if (ctl.negAcc) accReg <= -accReg;
      if (ctl.negA)   aReg   <= -aReg;
      if (ctl.negB)   bReg   <= -bReg;
      if (ctl.shl)    accReg <= accReg << ctl.shAmt;
      if (ctl.shr)    accReg <= $unsigned($signed(accReg) >>> ctl.shAmt);
      if (ctl.align) begin
        if (ctl.alignSigned) accReg <= $unsigned($signed(accReg) >>> {ctl.alignBytes, 3'b000});
        else                 accReg <= accReg >> {ctl.alignBytes, 3'b000};
      end
    end
  end

  assign accOut   = accReg;
  assign aOut     = aReg;
  assign bOut     = bReg;
  assign zeroFlag = (accReg == '0);

endmodule

// File: rtl/mac_engine.sv
module mac_engine #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [OP_W-1:0]  wrData,
  output logic [ACC_W-1:0] accOut,
  output logic [OP_W-1:0]  aOut,
  output logic [OP_W-1:0]  bOut,
  output logic             zeroFlag,
  output logic             ovfFlag,
  output logic             satFlag
);
  mac_pkg::ctl_t ctl;

  mac_ctrl #(.OP_W(OP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ctl(ctl)
  );

  mac_dpath #(.OP_W(OP_W), .ACC_W(ACC_W), .SAT_W(SAT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .accOut(accOut), .aOut(aOut), .bOut(bOut),
    .zeroFlag(zeroFlag), .ovfFlag(ovfFlag), .satFlag(satFlag)
  );

endmodule

// File: rtl/mac_engine_chk.sv
module mac_engine_chk #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input mac_pkg::ctl_t    ctl,
  input logic [ACC_W-1:0] accOut,
  input logic [OP_W-1:0]  aOut,
  input logic             zeroFlag,
  input logic             ovfFlag,
  input logic             satFlag
);
  localparam logic [ACC_W-1:0] HI_CLAMP = (ACC_W'(1) << (SAT_W - 1)) - 1;
  localparam logic [ACC_W-1:0] LO_CLAMP = ~HI_CLAMP;

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrAcc |=> (accOut == '0) && zeroFlag && !ovfFlag && !satFlag); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ctl.clrAcc) |=> ovfFlag); // R11

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satFlag) |-> (accOut == HI_CLAMP || accOut == LO_CLAMP)); // R5

  AST_NEG_ACC: assert property (@(posedge clk) disable iff (!rstN)
    ctl.negAcc |=> accOut == -$past(accOut)); // R8

  AST_INC_A: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doMac && ctl.incA) |=> aOut == $past(aOut) + 1'b1); // R6

  AST_SHR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shr && ctl.shAmt == 5'd1) |=>
      $signed(accOut) == ($signed($past(accOut)) >>> 1)); // R7

endmodule

bind mac_engine mac_engine_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .SAT_W(SAT_W)) chk_i (
  .clk(clk), .rstN(rstN), .ctl(ctl), .accOut(accOut), .aOut(aOut),
  .zeroFlag(zeroFlag), .ovfFlag(ovfFlag), .satFlag(satFlag)
);

// File: tb/mac_engine_tb_top.sv
module mac_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [39:0] accOut;
  logic [15:0] aOut, bOut;
  logic        zeroFlag, ovfFlag, satFlag;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_engine dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .accOut(accOut), .aOut(aOut), .bOut(bOut),
    .zeroFlag(zeroFlag), .ovfFlag(ovfFlag), .satFlag(satFlag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] adr, input logic [15:0] dat);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = adr; wrData = dat;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic mode(input logic [15:0] m);  wr(2'd0, m);   endtask
  task automatic opA(input logic [15:0] v);   wr(2'd1, v);   endtask
  task automatic opB(input logic [15:0] v);   wr(2'd2, v);   endtask
  task automatic cmd(input logic [15:0] c);   wr(2'd3, c);   endtask

  task automatic t_reset;
    chk("R10 reset acc", 64'(accOut), 64'd0);
    chk("R10 reset zero", 64'(zeroFlag), 64'd1);
    chk("R11 reset ovf", 64'(ovfFlag), 64'd0);
    chk("R5 reset sat", 64'(satFlag), 64'd0);
  endtask

  task automatic t_mul;
    mode(16'h02); opA(16'd3); opB(16'd5);
    chk("R1 product in one cycle", 64'(accOut), 64'd15);
    chk("R10 zero low", 64'(zeroFlag), 64'd0);
    mode(16'h03); opB(16'd5);
    chk("R2 accumulate", 64'(accOut), 64'd30);
    mode(16'h02); opB(16'd7);
    chk("R2 overwrite", 64'(accOut), 64'd21);
  endtask

  task automatic t_signed;
    mode(16'h02); opA(16'hFFFE); opB(16'd3);
    chk("R3 signed", 64'(accOut), 64'h00FF_FFFF_FFFA);
    mode(16'h00); opB(16'd3);
    chk("R3 unsigned", 64'(accOut), 64'h2FFFA);
  endtask

  task automatic t_frac;
    mode(16'h06); opA(16'h4000); opB(16'h4000);
    chk("R4 fractional", 64'(accOut), 64'h2000_0000);
  endtask

  task automatic t_round;
    mode(16'h0E); opA(16'h4000); opB(16'h0001);
    chk("R5 round up", 64'(accOut), 64'h1_0000);
    opA(16'h0001); opB(16'h3FFF);
    chk("R5 round down", 64'(accOut), 64'd0);
    chk("R10 zero after round", 64'(zeroFlag), 64'd1);
  endtask

  task automatic t_sat;
    cmd(16'h01); mode(16'h0F); opA(16'h7FFF); opB(16'h7FFF);
    chk("R5 no sat yet", 64'(accOut), 64'h7FFE_0000);
    chk("R5 sat flag clear", 64'(satFlag), 64'd0);
    opB(16'h7FFF);
    chk("R5 clamp high", 64'(accOut), 64'h7FFF_FFFF);
    chk("R5 sat flag high", 64'(satFlag), 64'd1);
    cmd(16'h01); opA(16'h8000); opB(16'h7FFF);
    chk("R5 negative in range", 64'(accOut), 64'hFF_8001_0000);
    opB(16'h7FFF);
    chk("R5 clamp low", 64'(accOut), 64'hFF_8000_0000);
    chk("R5 sat flag low", 64'(satFlag), 64'd1);
  endtask

  task automatic t_inc;
    cmd(16'h01); mode(16'h12); opA(16'd10); opB(16'd2);
    chk("R6 old A used", 64'(accOut), 64'd20);
    chk("R6 A advanced", 64'(aOut), 64'd11);
    opB(16'd2);
    chk("R6 second product", 64'(accOut), 64'd22);
    chk("R6 A advanced again", 64'(aOut), 64'd12);
    mode(16'h22); opA(16'd1); opB(16'd4);
    chk("R6 old B used", 64'(accOut), 64'd4);
    chk("R6 B advanced", 64'(bOut), 64'd5);
  endtask

  task automatic t_shift;
    mode(16'h02); opA(16'd3); opB(16'd5);
    cmd(16'h05);
    chk("R7 shl zero amount", 64'(accOut), 64'd30);
    cmd(16'h25);
    chk("R7 shl by 4", 64'(accOut), 64'd480);
    cmd(16'h1E);
    chk("R7 shr by 3", 64'(accOut), 64'd60);
    opA(16'hFFFE); opB(16'd3);
    cmd(16'h06);
    chk("R7 shr arithmetic", 64'(accOut), 64'hFF_FFFF_FFFD);
  endtask

  task automatic t_neg;
    mode(16'h02); opA(16'd3); opB(16'd5);
    cmd(16'h02);
    chk("R8 negate acc", 64'(accOut), 64'hFF_FFFF_FFF1);
    opA(16'd5); cmd(16'h03);
    chk("R8 negate A", 64'(aOut), 64'hFFFB);
    opB(16'd9); cmd(16'h04);
    chk("R8 negate B", 64'(bOut), 64'hFFF7);
  endtask

  task automatic t_align;
    mode(16'h00); opA(16'hFFFF); opB(16'hFFFF);
    cmd(16'h0F);
    chk("R9 align 1 zero fill", 64'(accOut), 64'h00FF_FE00);
    mode(16'h02); opA(16'hFFFE); opB(16'd3);
    cmd(16'h37);
    chk("R9 align 2 sign fill", 64'(accOut), 64'hFF_FFFF_FFFF);
    opB(16'd3);
    cmd(16'h17);
    chk("R9 align 2 zero fill", 64'(accOut), 64'h00_00FF_FFFF);
  endtask

  task automatic t_ovf;
    cmd(16'h01); mode(16'h06); opA(16'h7FFF); opB(16'h7FFF);
    cmd(16'h45);
    chk("R7 shl by 8", 64'(accOut), 64'h7F_FE00_0200);
    chk("R11 no ovf yet", 64'(ovfFlag), 64'd0);
    mode(16'h07); opB(16'h7FFF);
    chk("R11 wrapped sum", 64'(accOut), 64'h80_7DFE_0202);
    chk("R11 ovf set", 64'(ovfFlag), 64'd1);
    mode(16'h02); opA(16'd1); opB(16'd1);
    chk("R11 ovf sticky", 64'(ovfFlag), 64'd1);
    cmd(16'h01);
    chk("R10 clear acc", 64'(accOut), 64'd0);
    chk("R10 clear ovf", 64'(ovfFlag), 64'd0);
    chk("R10 zero after clear", 64'(zeroFlag), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul();
    t_signed();
    t_frac();
    t_round();
    t_sat();
    t_inc();
    t_shift();
    t_neg();
    t_align();
    t_ovf();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule